// File: doc/BRIEF.md
# Calendar Register Front-End with Key Guard and Init Handshake

This block sits between a simple register bus and a calendar counter core. It keeps the time, date, prescaler and control registers behind an unlock key. Software must write a two-byte key to a protection register before any of these registers accept a write. Loads into the counter are allowed only inside an initialisation window. Software opens that window by setting a request bit. It then waits for an acknowledge flag, which comes back a fixed number of cycles later and also freezes the counter through a hold output.

For reads, the block keeps shadow copies of the counter's time and date. The shadows are refreshed a fixed delay after each one-second tick from the core, and each refresh raises a synchronised flag that software clears. Reading the time shadow locks the date shadow until the date shadow is read. No refresh lands between the two reads, so the pair always comes from the same second.

Top module: `rtc_reg_front`

## Requirements
- R1: The key register is at address 5, and only bits 7:0 of a write to it are compared. Writing 0xCA and then, as the next key write, 0x53 unlocks the protected registers from the cycle after the second write.
- R2: A key write of 0xFF, or any key write that does not continue the sequence, leaves the block locked. A write of 0xCA always restarts the sequence, even from the unlocked state.
- R3: While locked, bus writes to time (0), date (1), prescaler (2), control (3) and the request bit of status (4) are ignored. The control register keeps its value, and no load pulse is issued.
- R4: Status bit 0 is the init request and status bit 1 is the acknowledge. The acknowledge follows the request SYNC_DLY (2) cycles later, both when it rises and when it falls, and `core_hold_o` equals the acknowledge.
- R5: Time, date and prescaler writes take effect only when the block is unlocked and the acknowledge is set. An accepted time or date write updates `core_time_o` or `core_date_o` and pulses `core_load_time_o` or `core_load_date_o` for one cycle, in the cycle after the write.
- R6: A tick sampled at clock edge k refreshes both shadows at edge k+2 and sets status bit 2 (synchronised). A status write with bit 2 at 0 clears the flag; a refresh in the same cycle wins. Clearing the flag needs no key.
- R7: A read of time sets a freeze that a read of date clears. Any refresh due while the freeze is set, or due in the same cycle as a time read, is dropped without setting the flag.
- R8: Read data is registered and appears in the cycle after the read. Time and date return the shadows, prescaler and control return their registers, status returns {sync, ack, req} in bits 2:0, and every other address returns 0.
- R9: After reset the block is locked. Request, acknowledge, flag, freeze, shadows, control, read data and load pulses are all 0, and the prescaler holds 0x007F00FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | AW (3) | Register address |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Registered read data |
| core_tick_i | input | 1 | One-second tick from the calendar core |
| core_time_i | input | TW (24) | Current time from the core |
| core_date_i | input | DTW (24) | Current date from the core |
| core_hold_o | output | 1 | Freezes core counting during init |
| core_load_time_o | output | 1 | One-cycle pulse to load a new time |
| core_load_date_o | output | 1 | One-cycle pulse to load a new date |
| core_time_o | output | TW (24) | Time value to load |
| core_date_o | output | DTW (24) | Date value to load |
| presc_o | output | DW (32) | Prescaler setting |
| ctrl_o | output | CTRL_W (8) | Control setting |

## Verification
Each result has its own latency. Read data, load pulses and register updates are due one cycle after the bus strobe. The acknowledge and hold follow a change of request by two cycles, and a shadow refresh with its flag lands two edges after the edge that samples the tick. The bench model keeps a queue of pending refreshes tagged with the edge at which each is due, and a two-deep history of the request. Every output is compared at the falling edge after each rising edge, so each result is checked in exactly the cycle it is due. The directed checks target the cases where timing matters most: a time read on the very edge a refresh is due, a refresh that falls inside a frozen window, and the sampling points just before and just after the acknowledge arrives.

// File: rtl/rtcfe_pkg.sv
package rtcfe_pkg;

    typedef enum logic [1:0] {
        KS_LOCKED,
        KS_HALF,
        KS_OPEN
    } key_state_e;

    localparam logic [7:0] KEY_ARM  = 8'hCA;
    localparam logic [7:0] KEY_OPEN = 8'h53;
    localparam logic [7:0] KEY_SHUT = 8'hFF;

    localparam int REG_TIME  = 0;
    localparam int REG_DATE  = 1;
    localparam int REG_PRESC = 2;
    localparam int REG_CTRL  = 3;
    localparam int REG_STAT  = 4;
    localparam int REG_KEY   = 5;

    localparam int STAT_REQ_BIT  = 0;
    localparam int STAT_ACK_BIT  = 1;
    localparam int STAT_SYNC_BIT = 2;

endpackage

// File: rtl/rtcfe_keylock.sv
module rtcfe_keylock
    import rtcfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr_i,
    input  logic [7:0] key_val_i,
    output logic       unlocked_o
);

    key_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_wr_i) begin
            if (key_val_i == KEY_ARM) begin
                st_d = KS_HALF;
            end else if (st_q == KS_HALF && key_val_i == KEY_OPEN) begin
                st_d = KS_OPEN;
            end else begin
                st_d = KS_LOCKED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= KS_LOCKED;
        else        st_q <= st_d;
    end

    assign unlocked_o = (st_q == KS_OPEN);

    AST_UNLOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked_o) |-> $past(key_wr_i && key_val_i == KEY_OPEN)); // R1

    AST_SHUT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr_i && key_val_i == KEY_SHUT) |=> !unlocked_o); // R2

endmodule

// File: rtl/rtcfe_ack_delay.sv
module rtcfe_ack_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic ack_o
);

    logic [DEPTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d[0] = req_i;
        for (int i = 1; i < DEPTH; i++) begin
            sr_d[i] = sr_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign ack_o = sr_q[DEPTH-1];

endmodule

// File: rtl/rtcfe_shadow.sv
module rtcfe_shadow #(
    parameter int TW    = 24,
    parameter int DTW   = 24,
    parameter int DEPTH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic [TW-1:0]  time_i,
    input  logic [DTW-1:0] date_i,
    input  logic           rd_time_i,
    input  logic           rd_date_i,
    input  logic           clr_sync_i,
    output logic [TW-1:0]  sh_time_o,
    output logic [DTW-1:0] sh_date_o,
    output logic           sync_o
);

    typedef struct packed {
        logic [TW-1:0]  sh_t;
        logic [DTW-1:0] sh_d;
        logic           sync;
        logic           frz;
    } shadow_s;

    shadow_s st_d, st_q;

    logic [DEPTH-1:0]           pv_d, pv_q;
    logic [DEPTH-1:0][TW-1:0]   pt_d, pt_q;
    logic [DEPTH-1:0][DTW-1:0]  pd_d, pd_q;
    logic                       refresh;

    always_comb begin
        pv_d[0] = tick_i;
        pt_d[0] = time_i;
        pd_d[0] = date_i;
        for (int i = 1; i < DEPTH; i++) begin
            pv_d[i] = pv_q[i-1];
            pt_d[i] = pt_q[i-1];
            pd_d[i] = pd_q[i-1];
        end

        refresh = pv_q[DEPTH-1] && !(st_q.frz || rd_time_i);

        st_d = st_q;
        if (refresh) begin
            st_d.sh_t = pt_q[DEPTH-1];
            st_d.sh_d = pd_q[DEPTH-1];
            st_d.sync = 1'b1;
        end else if (clr_sync_i) begin
            st_d.sync = 1'b0;
        end

        if (rd_time_i)      st_d.frz = 1'b1;
        else if (rd_date_i) st_d.frz = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            pv_q <= '0;
            pt_q <= '0;
            pd_q <= '0;
        end else begin
            st_q <= st_d;
            pv_q <= pv_d;
            pt_q <= pt_d;
            pd_q <= pd_d;
        end
    end

    assign sh_time_o = st_q.sh_t;
    assign sh_date_o = st_q.sh_d;
    assign sync_o    = st_q.sync;

    AST_FROZEN_DATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.frz |=> $stable(sh_date_o)); // R7

    AST_SYNC_FROM_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(pv_q[DEPTH-1])); // R6

endmodule

// File: rtl/rtc_reg_front.sv
module rtc_reg_front
    import rtcfe_pkg::*;
#(
    parameter int          AW        = 3,
    parameter int          DW        = 32,
    parameter int          TW        = 24,
    parameter int          DTW       = 24,
    parameter int          CTRL_W    = 8,
    parameter int          SYNC_DLY  = 2,
    parameter logic [31:0] PRESC_RST = 32'h007F00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    input  logic              core_tick_i,
    input  logic [TW-1:0]     core_time_i,
    input  logic [DTW-1:0]    core_date_i,
    output logic              core_hold_o,
    output logic              core_load_time_o,
    output logic              core_load_date_o,
    output logic [TW-1:0]     core_time_o,
    output logic [DTW-1:0]    core_date_o,
    output logic [DW-1:0]     presc_o,
    output logic [CTRL_W-1:0] ctrl_o
);

    localparam logic [AW-1:0] A_TIME  = AW'(REG_TIME);
    localparam logic [AW-1:0] A_DATE  = AW'(REG_DATE);
    localparam logic [AW-1:0] A_PRESC = AW'(REG_PRESC);
    localparam logic [AW-1:0] A_CTRL  = AW'(REG_CTRL);
    localparam logic [AW-1:0] A_STAT  = AW'(REG_STAT);
    localparam logic [AW-1:0] A_KEY   = AW'(REG_KEY);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DW-1:0]     presc;
        logic [TW-1:0]     time_v;
        logic [DTW-1:0]    date_v;
        logic              ld_t;
        logic              ld_d;
        logic              req;
        logic [DW-1:0]     rdata;
    } front_s;

    front_s st_d, st_q;

    logic sel_time, sel_date, sel_presc, sel_ctrl, sel_stat, sel_key;
    logic unlocked, init_ack, sync;
    logic [TW-1:0]  sh_time;
    logic [DTW-1:0] sh_date;

    assign sel_time  = (bus_addr_i == A_TIME);
    assign sel_date  = (bus_addr_i == A_DATE);
    assign sel_presc = (bus_addr_i == A_PRESC);
    assign sel_ctrl  = (bus_addr_i == A_CTRL);
    assign sel_stat  = (bus_addr_i == A_STAT);
    assign sel_key   = (bus_addr_i == A_KEY);

    rtcfe_keylock u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr_i   (bus_wr_i && sel_key),
        .key_val_i  (bus_wdata_i[7:0]),
        .unlocked_o (unlocked)
    );

    rtcfe_ack_delay #(.DEPTH(SYNC_DLY)) u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (st_q.req),
        .ack_o (init_ack)
    );

    rtcfe_shadow #(.TW(TW), .DTW(DTW), .DEPTH(SYNC_DLY)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (core_tick_i),
        .time_i     (core_time_i),
        .date_i     (core_date_i),
        .rd_time_i  (bus_rd_i && sel_time),
        .rd_date_i  (bus_rd_i && sel_date),
        .clr_sync_i (bus_wr_i && sel_stat && !bus_wdata_i[STAT_SYNC_BIT]),
        .sh_time_o  (sh_time),
        .sh_date_o  (sh_date),
        .sync_o     (sync)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ld_t = 1'b0;
        st_d.ld_d = 1'b0;

        if (bus_rd_i) begin
            st_d.rdata = '0;
            if (sel_time)  st_d.rdata = DW'(sh_time);
            if (sel_date)  st_d.rdata = DW'(sh_date);
            if (sel_presc) st_d.rdata = st_q.presc;
            if (sel_ctrl)  st_d.rdata = DW'(st_q.ctrl);
            if (sel_stat) begin
                st_d.rdata[STAT_REQ_BIT]  = st_q.req;
                st_d.rdata[STAT_ACK_BIT]  = init_ack;
                st_d.rdata[STAT_SYNC_BIT] = sync;
            end
        end

        if (bus_wr_i && unlocked) begin
            if (sel_ctrl) st_d.ctrl = bus_wdata_i[CTRL_W-1:0];
            if (sel_stat) st_d.req  = bus_wdata_i[STAT_REQ_BIT];
            if (init_ack) begin
                if (sel_time) begin
                    st_d.time_v = bus_wdata_i[TW-1:0];
                    st_d.ld_t   = 1'b1;
                end
                if (sel_date) begin
                    st_d.date_v = bus_wdata_i[DTW-1:0];
                    st_d.ld_d   = 1'b1;
                end
                if (sel_presc) st_d.presc = bus_wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.presc <= DW'(PRESC_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o      = st_q.rdata;
    assign core_hold_o      = init_ack;
    assign core_load_time_o = st_q.ld_t;
    assign core_load_date_o = st_q.ld_d;
    assign core_time_o      = st_q.time_v;
    assign core_date_o      = st_q.date_v;
    assign presc_o          = st_q.presc;
    assign ctrl_o           = st_q.ctrl;

    AST_LOCKED_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && sel_ctrl && !unlocked) |=> $stable(ctrl_o)); // R3

    AST_LOAD_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && sel_time && !(unlocked && core_hold_o)) |=> !core_load_time_o); // R5

    AST_PRESC_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !core_hold_o |=> $stable(presc_o)); // R5

endmodule

// File: tb/test_rtc_reg_front.sv
module test_rtc_reg_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick = 1'b0;
    logic [23:0] ctime = '0;
    logic [23:0] cdate = '0;
    logic        hold, ld_t, ld_d;
    logic [23:0] time_o, date_o;
    logic [31:0] presc;
    logic [7:0]  ctrl;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rtc_reg_front i_rtc_reg_front (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_wr_i         (bus_wr),
        .bus_rd_i         (bus_rd),
        .bus_addr_i       (addr),
        .bus_wdata_i      (wdata),
        .bus_rdata_o      (rdata),
        .core_tick_i      (tick),
        .core_time_i      (ctime),
        .core_date_i      (cdate),
        .core_hold_o      (hold),
        .core_load_time_o (ld_t),
        .core_load_date_o (ld_d),
        .core_time_o      (time_o),
        .core_date_o      (date_o),
        .presc_o          (presc),
        .ctrl_o           (ctrl)
    );

    // behavioural reference model
    typedef struct {
        int          due;
        logic [23:0] t;
        logic [23:0] d;
    } pend_t;

    pend_t       pend[$];
    bit          req_hist[$];
    int          cyc;
    int          m_key;
    bit          m_req, m_act, m_sync, m_frz, m_ldt, m_ldd;
    logic [31:0] m_rdata, m_presc;
    logic [7:0]  m_ctrl;
    logic [23:0] m_time, m_date, m_sht, m_shd;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend.delete();
            req_hist = '{0, 0};
            cyc = 0; m_key = 0;
            m_req = 0; m_act = 0; m_sync = 0; m_frz = 0; m_ldt = 0; m_ldd = 0;
            m_rdata = 0; m_presc = 32'h007F00FF; m_ctrl = 0;
            m_time = 0; m_date = 0; m_sht = 0; m_shd = 0;
        end else begin
            bit    open, fresh;
            pend_t e;
            if (bus_rd) begin
                case (addr)
                    3'd0: m_rdata = {8'h0, m_sht};
                    3'd1: m_rdata = {8'h0, m_shd};
                    3'd2: m_rdata = m_presc;
                    3'd3: m_rdata = {24'h0, m_ctrl};
                    3'd4: m_rdata = {29'h0, m_sync, m_act, m_req};
                    default: m_rdata = 0;
                endcase
            end
            fresh = 0;
            if (pend.size() > 0 && pend[0].due == cyc) begin
                e = pend.pop_front();
                if (!(m_frz || (bus_rd && addr == 3'd0))) begin
                    m_sht = e.t; m_shd = e.d; fresh = 1;
                end
            end
            if (fresh) m_sync = 1;
            else if (bus_wr && addr == 3'd4 && !wdata[2]) m_sync = 0;
            if (bus_rd && addr == 3'd0) m_frz = 1;
            else if (bus_rd && addr == 3'd1) m_frz = 0;
            if (tick) pend.push_back('{cyc + 2, ctime, cdate});
            open = (m_key == 2);
            m_ldt = 0; m_ldd = 0;
            if (bus_wr && open) begin
                if (addr == 3'd3) m_ctrl = wdata[7:0];
                if (addr == 3'd4) m_req = wdata[0];
                if (m_act && addr == 3'd0) begin m_time = wdata[23:0]; m_ldt = 1; end
                if (m_act && addr == 3'd1) begin m_date = wdata[23:0]; m_ldd = 1; end
                if (m_act && addr == 3'd2) m_presc = wdata;
            end
            if (bus_wr && addr == 3'd5) begin
                if (wdata[7:0] == 8'hCA) m_key = 1;
                else if (m_key == 1 && wdata[7:0] == 8'h53) m_key = 2;
                else m_key = 0;
            end
            m_act = req_hist.pop_front();
            req_hist.push_back(m_req);
            cyc++;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 rdata", rdata, m_rdata);
            chk("R4 hold", {31'h0, hold}, {31'h0, m_act});
            chk("R5 load_time", {31'h0, ld_t}, {31'h0, m_ldt});
            chk("R5 load_date", {31'h0, ld_d}, {31'h0, m_ldd});
            chk("R5 time_out", {8'h0, time_o}, {8'h0, m_time});
            chk("R5 date_out", {8'h0, date_o}, {8'h0, m_date});
            chk("R5 presc", presc, m_presc);
            chk("R3 ctrl", {24'h0, ctrl}, {24'h0, m_ctrl});
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; addr = a; wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; addr = a;
        @(negedge clk);
        d = rdata; bus_rd = 0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1;
        @(negedge clk);
        tick = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 hold after reset", {31'h0, hold}, 0);
        chk("R9 presc after reset", presc, 32'h007F00FF);
        chk("R9 ctrl after reset", {24'h0, ctrl}, 0);
        rd(3'd4, v); chk("R9 status after reset", v, 0);

        wr(3'd3, 32'hA5); rd(3'd3, v); chk("R3 locked ctrl write", v, 0);
        wr(3'd4, 32'h5);  rd(3'd4, v); chk("R3 locked init request", v, 0);

        wr(3'd5, 32'hCA); wr(3'd5, 32'h53);
        wr(3'd3, 32'h5A); rd(3'd3, v); chk("R1 unlocked ctrl write", v, 32'h5A);

        wr(3'd0, 32'h123456); chk("R5 no load without ack", {31'h0, ld_t}, 0);

        wr(3'd4, 32'h5);
        chk("R4 no ack yet", {31'h0, hold}, 0);
        @(negedge clk); @(negedge clk);
        chk("R4 ack after delay", {31'h0, hold}, 1);
        rd(3'd4, v); chk("R4 status req and ack", v, 32'h3);

        wr(3'd0, 32'h123456);
        chk("R5 load time pulse", {31'h0, ld_t}, 1);
        chk("R5 load time value", {8'h0, time_o}, 32'h123456);
        @(negedge clk);
        chk("R5 load pulse one cycle", {31'h0, ld_t}, 0);
        wr(3'd1, 32'h250101); chk("R5 load date value", {8'h0, date_o}, 32'h250101);
        wr(3'd2, 32'h00FF00FF); chk("R5 presc written", presc, 32'h00FF00FF);

        wr(3'd5, 32'hFF);
        wr(3'd3, 32'h11); rd(3'd3, v); chk("R2 locked by FF", v, 32'h5A);
        wr(3'd5, 32'hCA); wr(3'd5, 32'h00); wr(3'd5, 32'h53);
        wr(3'd3, 32'h22); rd(3'd3, v); chk("R2 broken sequence stays locked", v, 32'h5A);
        wr(3'd5, 32'hCA); wr(3'd5, 32'h53); wr(3'd5, 32'hCA);
        wr(3'd3, 32'h33); rd(3'd3, v); chk("R2 CA relocks", v, 32'h5A);

        wr(3'd5, 32'hCA); wr(3'd5, 32'h53);
        wr(3'd4, 32'h4);
        chk("R4 ack still high", {31'h0, hold}, 1);
        @(negedge clk); @(negedge clk);
        chk("R4 ack dropped", {31'h0, hold}, 0);

        ctime = 24'h101010; cdate = 24'h240315;
        pulse_tick();
        @(negedge clk);
        rd(3'd4, v); chk("R6 sync flag set", v, 32'h4);
        rd(3'd0, v); chk("R6 shadow time", v, 32'h101010);
        rd(3'd1, v); chk("R6 shadow date", v, 32'h240315);
        wr(3'd4, 32'h0); rd(3'd4, v); chk("R6 sync cleared", v, 0);

        rd(3'd0, v);
        ctime = 24'h111111; cdate = 24'h240316;
        pulse_tick();
        repeat (3) @(negedge clk);
        rd(3'd4, v); chk("R7 refresh dropped while frozen", v, 0);
        rd(3'd1, v); chk("R7 date held", v, 32'h240315);

        pulse_tick();
        rd(3'd0, v); chk("R7 time read on refresh edge", v, 32'h101010);
        rd(3'd4, v); chk("R7 no sync on same edge", v, 0);
        rd(3'd1, v); chk("R7 date coherent", v, 32'h240315);

        pulse_tick();
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk("R6 new time after unfreeze", v, 32'h111111);
        rd(3'd1, v); chk("R6 new date after unfreeze", v, 32'h240316);
        rd(3'd7, v); chk("R8 unmapped reads zero", v, 0);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule